// File: doc/BRIEF.md
# Prescaled Lookup Transform with Saturation

This block maps a wide signed sample onto a programmable table. A configurable arithmetic right shift (0 to 16 places) moves the wanted 8-bit window of the 22-bit sample down to the least significant end. That window then serves as a table address. The upper six bits of the window pick one of 64 words of 32 bits. The lower two bits pick one byte of that word for a separate byte-wide output. The block also tests whether the shift threw away significant bits. It can apply this test under a signed rule (window range -128..127) or an unsigned rule (window range 0..255). When the test fails, or when the caller marks the sample as overflowed, the block reads one of two saturation words instead of the table, and the byte output is forced to that word's most significant byte.

Samples enter on a valid/ready stream and leave on a valid/ready stream through a single registered stage. A sample is accepted when `in_valid` and `in_ready` are both high. Its result is presented on the next cycle and is held unchanged while `out_ready` is low. The input side stalls only while a result is waiting and the consumer is not taking it. A host write port loads the table words and the two saturation words.

Top module: `lut_xform`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and all 64 table words and both saturation words read as zero.
- R2: The address window is the low 8 bits of the sample arithmetically right-shifted by `cfg_shift`. Any shift value above 16 acts as 16.
- R3: With no overflow and no select error, `out_word` is table word `window[7:2]`. `out_byte` is byte `window[1:0]` of that word, where byte 0 is bits 7:0 and byte 3 is bits 31:24.
- R4: With `cfg_unsigned`=0, a select error occurs when the shifted value lies outside -128..127. It is an over-select for a sample with bit 21 = 0 and an under-select for one with bit 21 = 1.
- R5: With `cfg_unsigned`=1, a select error occurs when the shifted value lies outside 0..255. Every negative sample is therefore an under-select, and a positive sample in error is an over-select.
- R6: `in_pos_ovf` or an over-select reads the upper saturation word. `in_neg_ovf` or an under-select reads the lower saturation word. In either case `out_byte` is bits 31:24 of that word.
- R7: The input overflow flags take priority over select errors, and `in_pos_ovf` takes priority over `in_neg_ovf`.
- R8: A result appears with `out_valid`=1 in the cycle after its sample is accepted. While `out_ready` is 0, `out_valid`, `out_word` and `out_byte` hold. `out_valid` drops after a handshake that has no new acceptance.
- R9: `in_ready` is 0 exactly when `out_valid` is 1 and `out_ready` is 0.
- R10: A host write with `host_we`=1 stores `host_wdata` at table word `host_addr` for addresses 0..63, in the upper saturation word at 64, and in the lower saturation word at 65. Addresses 66..127 change nothing. A sample accepted in the same cycle as a write reads the content from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_shift | input | 5 | Right-shift amount, 0..16 (larger values act as 16) |
| cfg_unsigned | input | 1 | 1 = unsigned window rule, 0 = signed |
| in_valid | input | 1 | Sample stream valid |
| in_ready | output | 1 | Sample stream ready |
| in_sample | input | 22 | Two's complement sample |
| in_pos_ovf | input | 1 | Sample carries a positive overflow |
| in_neg_ovf | input | 1 | Sample carries a negative overflow |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_word | output | 32 | Selected table or saturation word |
| out_byte | output | 8 | Selected byte of `out_word` |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 7 | Host word address (64 upper, 65 lower saturation) |
| host_wdata | input | 32 | Host write data |

## Verification
The sample is driven on a falling edge and accepted at the next rising edge. Word, byte and valid are therefore due at the falling edge right after that. Each bench check samples there, with the reference computed from a shadow copy of the host writes. Host writes land on one rising edge and are visible to a sample accepted at any later edge. The same-cycle case is checked against the pre-write value. The stall cases hold `out_ready` low for several cycles and re-check the held result and `in_ready` at each falling edge. The next result is then checked one cycle after the handshake.

// File: rtl/lut_xform_pkg.sv
package lut_xform_pkg;
  // which storage feeds the registered read
  typedef enum logic [1:0] {
    SRC_TABLE = 2'd0,
    SRC_UPPER = 2'd1,
    SRC_LOWER = 2'd2
  } src_e;
endpackage

// File: rtl/lut_xform_prescale.sv
module lut_xform_prescale #(
  parameter int DATA_W    = 22,
  parameter int FIELD_W   = 8,
  parameter int SHIFT_W   = 5,
  parameter int MAX_SHIFT = 16
) (
  input  logic [DATA_W-1:0]  sample,
  input  logic [SHIFT_W-1:0] shift,
  input  logic               unsigned_mode,
  output logic [FIELD_W-1:0] field,
  output logic               over_sel,
  output logic               under_sel
);
  localparam int TOP_S_W = DATA_W - FIELD_W + 1;
  localparam int TOP_U_W = DATA_W - FIELD_W;

  logic [SHIFT_W-1:0]       sh_eff;
  logic signed [DATA_W-1:0] shifted;
  logic [TOP_S_W-1:0]       top_s;
  logic [TOP_U_W-1:0]       top_u;
  logic                     sel_err;

  always_comb begin
    sh_eff  = (shift > SHIFT_W'(MAX_SHIFT)) ? SHIFT_W'(MAX_SHIFT) : shift;
    shifted = $signed(sample) >>> sh_eff;
    field   = shifted[FIELD_W-1:0];
    top_s   = shifted[DATA_W-1:FIELD_W-1];
    top_u   = shifted[DATA_W-1:FIELD_W];
    // signed rule: window msb and everything above must agree
    // unsigned rule: everything above the window must be zero
    sel_err   = unsigned_mode ? (|top_u) : !((&top_s) || !(|top_s));
    over_sel  = sel_err && !sample[DATA_W-1];
    under_sel = sel_err &&  sample[DATA_W-1];
  end
endmodule

// File: rtl/lut_xform_steer.sv
module lut_xform_steer
  import lut_xform_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int IDX_W   = 6,
  parameter int BSEL_W  = 2
) (
  input  logic [FIELD_W-1:0] field,
  input  logic               pos_ovf,
  input  logic               neg_ovf,
  input  logic               over_sel,
  input  logic               under_sel,
  output src_e               src,
  output logic [IDX_W-1:0]   word_idx,
  output logic [BSEL_W-1:0]  byte_idx
);
  always_comb begin
    word_idx = field[FIELD_W-1:BSEL_W];
    // caller flags outrank select errors; positive outranks negative
    if (pos_ovf)        src = SRC_UPPER;
    else if (neg_ovf)   src = SRC_LOWER;
    else if (over_sel)  src = SRC_UPPER;
    else if (under_sel) src = SRC_LOWER;
    else                src = SRC_TABLE;
    byte_idx = (src == SRC_TABLE) ? field[BSEL_W-1:0] : '1;
  end
endmodule

// File: rtl/lut_xform_table.sv
module lut_xform_table
  import lut_xform_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 6,
  parameter int BSEL_W  = 2,
  parameter int HOST_AW = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [WORD_W-1:0]  host_wdata,
  input  logic               load,
  input  src_e               src,
  input  logic [IDX_W-1:0]   word_idx,
  input  logic [BSEL_W-1:0]  byte_idx,
  output logic [WORD_W-1:0]  word_q,
  output logic [7:0]         byte_q
);
  localparam int DEPTH    = 2 ** IDX_W;
  localparam int N_BYTES  = 2 ** BSEL_W;
  localparam int UP_ADDR  = DEPTH;
  localparam int LO_ADDR  = DEPTH + 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] sat_up, sat_lo;
  logic [WORD_W-1:0] rd_word;
  logic [7:0]        lanes [N_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      sat_up <= '0;
      sat_lo <= '0;
    end else if (host_we) begin
      for (int i = 0; i < DEPTH; i++)
        if (host_addr == HOST_AW'(i)) mem[i] <= host_wdata;
      if (host_addr == HOST_AW'(UP_ADDR)) sat_up <= host_wdata;
      if (host_addr == HOST_AW'(LO_ADDR)) sat_lo <= host_wdata;
    end
  end

  always_comb begin
    case (src)
      SRC_UPPER: rd_word = sat_up;
      SRC_LOWER: rd_word = sat_lo;
      default:   rd_word = mem[word_idx];
    endcase
  end

  for (genvar b = 0; b < N_BYTES; b++) begin : g_lane
    assign lanes[b] = rd_word[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      byte_q <= '0;
    end else if (load) begin
      word_q <= rd_word;
      byte_q <= lanes[byte_idx];
    end
  end
endmodule

// File: rtl/lut_xform.sv
module lut_xform
  import lut_xform_pkg::*;
#(
  parameter int DATA_W    = 22,
  parameter int FIELD_W   = 8,
  parameter int SHIFT_W   = 5,
  parameter int MAX_SHIFT = 16,
  parameter int WORD_W    = 32,
  parameter int BSEL_W    = 2,
  parameter int IDX_W     = FIELD_W - BSEL_W,
  parameter int HOST_AW   = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic               cfg_unsigned,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_sample,
  input  logic               in_pos_ovf,
  input  logic               in_neg_ovf,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_word,
  output logic [7:0]         out_byte,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [WORD_W-1:0]  host_wdata
);
  logic [FIELD_W-1:0] field;
  logic               over_sel, under_sel;
  src_e               src;
  logic [IDX_W-1:0]   word_idx;
  logic [BSEL_W-1:0]  byte_idx;
  logic               accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  lut_xform_prescale #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W), .SHIFT_W(SHIFT_W), .MAX_SHIFT(MAX_SHIFT)
  ) u_pre (
    .sample(in_sample), .shift(cfg_shift), .unsigned_mode(cfg_unsigned),
    .field(field), .over_sel(over_sel), .under_sel(under_sel)
  );

  lut_xform_steer #(
    .FIELD_W(FIELD_W), .IDX_W(IDX_W), .BSEL_W(BSEL_W)
  ) u_steer (
    .field(field), .pos_ovf(in_pos_ovf), .neg_ovf(in_neg_ovf),
    .over_sel(over_sel), .under_sel(under_sel),
    .src(src), .word_idx(word_idx), .byte_idx(byte_idx)
  );

  lut_xform_table #(
    .WORD_W(WORD_W), .IDX_W(IDX_W), .BSEL_W(BSEL_W), .HOST_AW(HOST_AW)
  ) u_tab (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .load(accept), .src(src), .word_idx(word_idx), .byte_idx(byte_idx),
    .word_q(out_word), .byte_q(out_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (accept)    out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end
endmodule

// File: rtl/lut_xform_checks.sv
module lut_xform_checks #(
  parameter int DATA_W  = 22,
  parameter int SHIFT_W = 5,
  parameter int WORD_W  = 32,
  parameter int HOST_AW = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [SHIFT_W-1:0] cfg_shift,
  input logic               cfg_unsigned,
  input logic               in_valid,
  input logic               in_ready,
  input logic [DATA_W-1:0]  in_sample,
  input logic               in_pos_ovf,
  input logic               in_neg_ovf,
  input logic               out_valid,
  input logic               out_ready,
  input logic [WORD_W-1:0]  out_word,
  input logic [7:0]         out_byte,
  input logic               host_we,
  input logic [HOST_AW-1:0] host_addr,
  input logic [WORD_W-1:0]  host_wdata
);
  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_byte)));

  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !in_valid) |=> !out_valid);

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  assert_sat_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_pos_ovf || in_neg_ovf)) |=> (out_byte == out_word[31:24]));
endmodule

bind lut_xform lut_xform_checks #(
  .DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .WORD_W(WORD_W), .HOST_AW(HOST_AW)
) u_checks (.*);

// File: tb/lut_xform_bench.sv
module lut_xform_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_shift = '0;
  logic        cfg_unsigned = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [21:0] in_sample = '0;
  logic        in_pos_ovf = 1'b0;
  logic        in_neg_ovf = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic [7:0]  out_byte;
  logic        host_we = 1'b0;
  logic [6:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [31:0] m_tab [64];
  logic [31:0] m_up, m_lo;

  always #(CLK_PERIOD/2) clk = ~clk;

  lut_xform u_lut_xform (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_unsigned(cfg_unsigned),
    .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
    .in_pos_ovf(in_pos_ovf), .in_neg_ovf(in_neg_ovf),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_byte(out_byte),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference from the requirement text: range test on the shifted integer
  function automatic void ref_out(input logic [21:0] s, input logic [4:0] sh, input logic uns,
                                  input logic pov, input logic nov,
                                  output logic [31:0] w, output logic [7:0] b);
    int v, shv, win;
    bit err;
    v   = int'({{10{s[21]}}, s});
    shv = (int'(sh) > 16) ? 16 : int'(sh);
    v   = v >>> shv;
    win = v & 255;
    err = uns ? (v < 0 || v > 255) : (v < -128 || v > 127);
    if (pov)                    w = m_up;
    else if (nov)               w = m_lo;
    else if (err && !s[21])     w = m_up;
    else if (err)               w = m_lo;
    else                        w = m_tab[win / 4];
    if (pov || nov || err) b = w[31:24];
    else                   b = w[8*(win % 4) +: 8];
  endfunction

  task automatic host_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    if (a < 64)       m_tab[a] = d;
    else if (a == 64) m_up = d;
    else if (a == 65) m_lo = d;
  endtask

  task automatic xfer(input logic [21:0] s, input logic [4:0] sh, input logic uns,
                      input logic pov, input logic nov, input string tag);
    logic [31:0] ew; logic [7:0] eb;
    ref_out(s, sh, uns, pov, nov, ew, eb);
    @(negedge clk);
    in_valid = 1'b1; in_sample = s; cfg_shift = sh; cfg_unsigned = uns;
    in_pos_ovf = pov; in_neg_ovf = nov;
    @(negedge clk);
    in_valid = 1'b0; in_pos_ovf = 1'b0; in_neg_ovf = 1'b0;
    check({tag, " valid"}, 32'(out_valid), 32'd1);
    check({tag, " word"}, out_word, ew);
    check({tag, " byte"}, 32'(out_byte), 32'(eb));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] ew, hold_w; logic [7:0] eb;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) m_tab[i] = '0;
    m_up = '0; m_lo = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid", 32'(out_valid), 32'd0);
    check("R1 in_ready", 32'(in_ready), 32'd1);
    xfer(22'd0, 5'd0, 1'b0, 1'b0, 1'b0, "R1 table zero");
    xfer(22'd0, 5'd0, 1'b0, 1'b1, 1'b0, "R1 upper zero");
    xfer(22'd0, 5'd0, 1'b0, 1'b0, 1'b1, "R1 lower zero");

    // R10 load everything
    for (int i = 0; i < 64; i++) host_write(7'(i), $urandom());
    host_write(7'd64, 32'hA1B2C3D4);
    host_write(7'd65, 32'h5E6F7081);

    // R3 table read, several byte lanes
    xfer(22'd165, 5'd0, 1'b1, 1'b0, 1'b0, "R3 unsigned 165");
    xfer(22'd6,   5'd0, 1'b0, 1'b0, 1'b0, "R3 lane 2");
    xfer(22'h3FFFFD, 5'd0, 1'b0, 1'b0, 1'b0, "R3 signed -3");
    // R2 shifting
    xfer(22'h000A50, 5'd4, 1'b1, 1'b0, 1'b0, "R2 shift 4");
    xfer(22'h1FFFFF, 5'd16, 1'b0, 1'b0, 1'b0, "R2 shift 16");
    xfer(22'h1FFFFF, 5'd20, 1'b0, 1'b0, 1'b0, "R2 shift clamp");
    xfer(22'h2FFFFF, 5'd31, 1'b0, 1'b0, 1'b0, "R2 neg clamp");
    // R4 signed rule
    xfer(22'd165, 5'd0, 1'b0, 1'b0, 1'b0, "R4 over-select");
    xfer(22'd127, 5'd0, 1'b0, 1'b0, 1'b0, "R4 edge 127");
    xfer(22'h3FFF7F, 5'd0, 1'b0, 1'b0, 1'b0, "R4 under-select");
    xfer(22'h3FFF80, 5'd0, 1'b0, 1'b0, 1'b0, "R4 edge -128");
    // R5 unsigned rule
    xfer(22'd255, 5'd0, 1'b1, 1'b0, 1'b0, "R5 edge 255");
    xfer(22'd256, 5'd0, 1'b1, 1'b0, 1'b0, "R5 over-select");
    xfer(22'h3FFFFD, 5'd0, 1'b1, 1'b0, 1'b0, "R5 negative under");
    // R6 overflow flags
    xfer(22'd5, 5'd0, 1'b0, 1'b1, 1'b0, "R6 pos ovf");
    xfer(22'd5, 5'd0, 1'b0, 1'b0, 1'b1, "R6 neg ovf");
    // R7 priority
    xfer(22'd5, 5'd0, 1'b0, 1'b1, 1'b1, "R7 both ovf");
    xfer(22'd300, 5'd0, 1'b0, 1'b0, 1'b1, "R7 neg ovf over-select");
    xfer(22'h3FF000, 5'd0, 1'b0, 1'b1, 1'b0, "R7 pos ovf under-select");

    // R10 ignored addresses leave saturation words and table alone
    host_write(7'd100, 32'hDEADBEEF);
    host_write(7'd66, 32'hCAFEF00D);
    xfer(22'd0, 5'd0, 1'b0, 1'b1, 1'b0, "R10 upper kept");
    xfer(22'd0, 5'd0, 1'b0, 1'b0, 1'b1, "R10 lower kept");
    xfer(22'd4, 5'd0, 1'b0, 1'b0, 1'b0, "R10 word 1 kept");

    // R10 same-cycle write and read returns old content
    ref_out(22'd8, 5'd0, 1'b0, 1'b0, 1'b0, ew, eb);
    @(negedge clk);
    host_we = 1'b1; host_addr = 7'd2; host_wdata = 32'h13572468;
    in_valid = 1'b1; in_sample = 22'd8; cfg_shift = 5'd0; cfg_unsigned = 1'b0;
    @(negedge clk);
    host_we = 1'b0; in_valid = 1'b0;
    m_tab[2] = 32'h13572468;
    check("R10 read-old word", out_word, ew);
    xfer(22'd8, 5'd0, 1'b0, 1'b0, 1'b0, "R10 new word");

    // R8 / R9 back-pressure
    ref_out(22'd12, 5'd0, 1'b0, 1'b0, 1'b0, ew, eb);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_sample = 22'd12;
    @(negedge clk);
    in_sample = 22'd16;
    check("R9 stalled ready", 32'(in_ready), 32'd0);
    hold_w = out_word;
    check("R8 stalled word", out_word, ew);
    repeat (3) begin
      @(negedge clk);
      check("R8 hold valid", 32'(out_valid), 32'd1);
      check("R8 hold word", out_word, hold_w);
      check("R9 still stalled", 32'(in_ready), 32'd0);
    end
    ref_out(22'd16, 5'd0, 1'b0, 1'b0, 1'b0, ew, eb);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next valid", 32'(out_valid), 32'd1);
    check("R8 next word", out_word, ew);
    check("R8 next byte", 32'(out_byte), 32'(eb));
    @(negedge clk);
    check("R8 drained", 32'(out_valid), 32'd0);

    // random mix, R2..R7
    for (int n = 0; n < 400; n++) begin
      logic [21:0] s; logic [4:0] sh; logic u, p, q;
      s  = 22'($urandom());
      sh = 5'($urandom_range(0, 18));
      u  = 1'($urandom());
      p  = ($urandom_range(0, 15) == 0);
      q  = ($urandom_range(0, 15) == 0);
      if ((n % 3) == 0) s = 22'($signed(8'($urandom())) <<< sh);
      xfer(s, sh, u, p, q, "R3 random");
      if ((n % 50) == 7) host_write(7'($urandom_range(0, 65)), $urandom());
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule